// File: doc/BRIEF.md
# Bus-Segment Address Decoder with Upstream Enable

This block turns a bus address into a one-hot set of slave selects for a small microcontroller bus segment. Three fixed-size windows are recognised: a program ROM, a data RAM and the window behind an AHB-to-APB bridge. Any address that falls into none of them selects a default slave, which answers with an error response. The selects are a purely combinational function of the address and of an enable input. The bus fabric samples them in the address phase.

The enable input lets the decoder sit behind a global decoder. When the enable is low, every select is forced low. Each window can be switched off per instance by a parameter. One instance can then serve the code bus segment with only the ROM window enabled. A second instance serves the system bus segment with the RAM and bridge windows enabled. Addresses of a disabled window fall through to that instance's own default slave. Window matching compares only the address bits above the window size. The low bits never change the decision.

Top module: `ahb_addr_decoder`

## Requirements
- R1: With the enable high and the ROM window enabled, an address in [ROM_BASE, ROM_BASE+64 KB) drives `sel_out` to 4'b0001 (bit 0 = ROM).
- R2: With the enable high and the RAM window enabled, an address in [RAM_BASE, RAM_BASE+64 KB) drives `sel_out` to 4'b0010 (bit 1 = RAM).
- R3: With the enable high and the bridge window enabled, an address in [APB_BASE, APB_BASE+64 KB) drives `sel_out` to 4'b0100 (bit 2 = bridge).
- R4: With the enable high, an address that lies in no enabled window drives `sel_out` to 4'b1000 (bit 3 = default slave).
- R5: With the enable low, `sel_out` is 4'b0000 for every address.
- R6: A window whose bit in REGION_EN is 0 (bit 0 ROM, bit 1 RAM, bit 2 bridge) never asserts its select, and its addresses select the default slave.
- R7: Window edges are exact. The last byte of a window (base+0xFFFF) selects that window, and the next address (base+0x10000) does not.
- R8: While the enable is high, exactly one bit of `sel_out` is high.
- R9: The selects change in the same cycle as the address and the enable, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| haddr | input | ADDR_W (32) | Bus address of the current address phase |
| sel_in | input | 1 | Enable from an upstream decoder; low forces all selects low |
| sel_out | output | 4 | One-hot selects: bit 0 ROM, bit 1 RAM, bit 2 bridge, bit 3 default slave |

## Verification
The hardest case to reach is a select that falls through because of configuration rather than because the address is unmapped. A RAM or bridge address must reach the default slave only in an instance where that window is disabled. The bench therefore drives the same address into two instances side by side: one with every window enabled, and one configured for the code bus with only ROM enabled. The two instances must disagree on exactly those addresses. Window edges are hit one byte inside and one byte past each window. A sweep across the top address bits checks the one-hot property everywhere else.

// File: rtl/ahb_dec_pkg.sv
package ahb_dec_pkg;
  // slot order is the bit order of the select vector
  typedef enum int unsigned {
    SLOT_ROM = 0,
    SLOT_RAM = 1,
    SLOT_APB = 2
  } slot_e;

  localparam int NUM_SLOTS     = 3;
  localparam int MIN_SIZE_LOG2 = 10;   // smallest legal window is 1 KB
endpackage

// File: rtl/region_match.sv
module region_match #(
  parameter int             TAG_W    = 16,
  parameter logic [TAG_W-1:0] BASE_TAG = '0,
  parameter bit             ENABLE   = 1'b1
) (
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  generate
    if (ENABLE) begin : g_on
      assign hit = (tag == BASE_TAG);
    end else begin : g_off
      logic unused_tag;
      assign unused_tag = ^tag;
      assign hit        = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hit_priority.sv
module hit_priority #(
  parameter int N = 3
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] grant
);
  // lowest slot wins if misconfigured bases overlap
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) grant = N'(1) << i;
    end
  end
endmodule

// File: rtl/default_fill.sv
module default_fill #(
  parameter int N = 3
) (
  input  logic [N-1:0] grant,
  input  logic         en,
  output logic [N:0]   sel
);
  always_comb begin
    if (en) sel = {~|grant, grant};
    else    sel = '0;
  end
endmodule

// File: rtl/ahb_addr_decoder.sv
module ahb_addr_decoder
  import ahb_dec_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                SIZE_LOG2 = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] APB_BASE  = 32'h4000_0000,
  parameter logic [2:0]        REGION_EN = 3'b111
) (
  input  logic [ADDR_W-1:0]  haddr,
  input  logic               sel_in,
  output logic [NUM_SLOTS:0] sel_out
);
  localparam int TAG_W = ADDR_W - SIZE_LOG2;
  localparam logic [NUM_SLOTS-1:0][ADDR_W-1:0] BASES = {APB_BASE, RAM_BASE, ROM_BASE};

  logic [TAG_W-1:0]     tag;
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] grant;
  logic                 unused_offset;

  assign tag           = haddr[ADDR_W-1:SIZE_LOG2];
  assign unused_offset = ^haddr[SIZE_LOG2-1:0];

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_region
      region_match #(
        .TAG_W   (TAG_W),
        .BASE_TAG(BASES[g][ADDR_W-1:SIZE_LOG2]),
        .ENABLE  (REGION_EN[g])
      ) u_match (
        .tag(tag),
        .hit(hit[g])
      );
    end
  endgenerate

  hit_priority #(.N(NUM_SLOTS)) u_prio (
    .hit  (hit),
    .grant(grant)
  );

  default_fill #(.N(NUM_SLOTS)) u_fill (
    .grant(grant),
    .en   (sel_in),
    .sel  (sel_out)
  );
endmodule

// File: rtl/ahb_addr_decoder_chk.sv
module ahb_addr_decoder_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                SIZE_LOG2 = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] APB_BASE  = 32'h4000_0000,
  parameter logic [2:0]        REGION_EN = 3'b111
) (
  input logic [ADDR_W-1:0] haddr,
  input logic              sel_in,
  input logic [3:0]        sel_out
);
  logic in_rom, in_ram, in_apb, unused_low;
  assign in_rom     = REGION_EN[0] && (haddr[ADDR_W-1:SIZE_LOG2] == ROM_BASE[ADDR_W-1:SIZE_LOG2]);
  assign in_ram     = REGION_EN[1] && (haddr[ADDR_W-1:SIZE_LOG2] == RAM_BASE[ADDR_W-1:SIZE_LOG2]);
  assign in_apb     = REGION_EN[2] && (haddr[ADDR_W-1:SIZE_LOG2] == APB_BASE[ADDR_W-1:SIZE_LOG2]);
  assign unused_low = ^haddr[SIZE_LOG2-1:0];

  always_comb begin
    if (!sel_in) AST_GATED_LOW: assert (sel_out == 4'b0000);                    // R5
    if (sel_in) AST_ONE_HOT: assert ($countones(sel_out) == 1);                 // R8
    if (sel_in && in_rom) AST_ROM_SEL: assert (sel_out[0]);                     // R1
    if (sel_in && in_ram && !in_rom) AST_RAM_SEL: assert (sel_out[1]);          // R2
    if (sel_in && in_apb && !in_rom && !in_ram) AST_APB_SEL: assert (sel_out[2]); // R3
    if (sel_in && !in_rom && !in_ram && !in_apb) AST_DEFAULT_SEL: assert (sel_out[3]); // R4
    if (!REGION_EN[1]) AST_RAM_OFF: assert (!sel_out[1]);                       // R6
  end
endmodule

bind ahb_addr_decoder ahb_addr_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .SIZE_LOG2(SIZE_LOG2),
  .ROM_BASE (ROM_BASE),
  .RAM_BASE (RAM_BASE),
  .APB_BASE (APB_BASE),
  .REGION_EN(REGION_EN)
) u_chk (
  .haddr  (haddr),
  .sel_in (sel_in),
  .sel_out(sel_out)
);

// File: tb/ahb_addr_decoder_tb.sv
module ahb_addr_decoder_tb;
  logic        clk = 1'b0;
  logic [31:0] haddr = '0;
  logic        sel_in = 1'b0;
  logic [3:0]  sel_sys, sel_code;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  ahb_addr_decoder u_dut (
    .haddr(haddr), .sel_in(sel_in), .sel_out(sel_sys)
  );

  ahb_addr_decoder #(.REGION_EN(3'b001)) u_code (
    .haddr(haddr), .sel_in(sel_in), .sel_out(sel_code)
  );

  // {addr, enable, expected all-enabled, expected code-bus}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 4'b0001, 4'b0001},
    {32'h0000_FFFF, 1'b1, 4'b0001, 4'b0001},
    {32'h0001_0000, 1'b1, 4'b1000, 4'b1000},
    {32'h1FFF_FFFF, 1'b1, 4'b1000, 4'b1000},
    {32'h2000_0000, 1'b1, 4'b0010, 4'b1000},
    {32'h2000_ABCD, 1'b1, 4'b0010, 4'b1000},
    {32'h2000_FFFF, 1'b1, 4'b0010, 4'b1000},
    {32'h2001_0000, 1'b1, 4'b1000, 4'b1000},
    {32'h4000_0000, 1'b1, 4'b0100, 4'b1000},
    {32'h4000_FFFC, 1'b1, 4'b0100, 4'b1000},
    {32'h4001_0000, 1'b1, 4'b1000, 4'b1000},
    {32'hFFFF_FFFF, 1'b1, 4'b1000, 4'b1000},
    {32'h0000_1234, 1'b0, 4'b0000, 4'b0000},
    {32'h2000_0000, 1'b0, 4'b0000, 4'b0000},
    {32'h4000_0010, 1'b0, 4'b0000, 4'b0000},
    {32'hDEAD_BEEF, 1'b0, 4'b0000, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] a,
                       input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%b expected=%b", req, a, act, exp);
    end
  endtask

  function automatic string req_of(input logic [31:0] a, input logic en);
    if (!en) return "R5";
    case (a[31:16])
      16'h0000: return "R1";
      16'h2000: return "R2";
      16'h4000: return "R3";
      default:  return "R4/R7";
    endcase
  endfunction

  initial begin
    // start-up state with enable low: R5
    @(negedge clk);
    check("R5", haddr, sel_sys, 4'b0000);

    // vector table: R1 R2 R3 R4 R5 R7, and R6 on the code-bus instance
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      haddr  = VEC[i][40:9];
      sel_in = VEC[i][8];
      @(negedge clk);
      check(req_of(VEC[i][40:9], VEC[i][8]), haddr, sel_sys, VEC[i][7:4]);
      check("R6", haddr, sel_code, VEC[i][3:0]);
    end

    // R9: selects follow the inputs within the same cycle, no register stage
    @(posedge clk);
    haddr = 32'h2000_0040; sel_in = 1'b1;
    #1 check("R9", haddr, sel_sys, 4'b0010);
    haddr = 32'h4000_0040;
    #0.5 check("R9", haddr, sel_sys, 4'b0100);
    sel_in = 1'b0;
    #0.5 check("R9", haddr, sel_sys, 4'b0000);

    // R8: sweep the upper bits, exactly one select per instance
    sel_in = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk);
      haddr = (32'(i) << 26) | 32'h0000_7F00;
      @(negedge clk);
      n_chk++;
      if ($countones(sel_sys) != 1 || $countones(sel_code) != 1) begin
        n_bad++;
        $display("FAIL R8 addr=%h actual=%b/%b expected=one-hot", haddr, sel_sys, sel_code);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule